// File: doc/BRIEF.md
# Multiplexed-Input Scan Register Bank

This block holds the state flip-flops of a small sequential design and gives them a second use as a serial test path. While the test-mode line is low, every flip-flop loads its next-state value from the surrounding combinational logic, so the design behaves exactly as it would without test support. While the test-mode line is high, the flip-flops form one shift register. It runs from a dedicated serial input, through stage 0, up to the last stage, and on to a dedicated serial output.

A tester drives a structural test in three steps. It first holds test mode high for one clock per stage to load a chosen state. It then drops test mode for exactly one clock, so that the logic's response is captured. Finally it raises test mode again and clocks the captured state out. The serial output always shows the last stage, so the unload of one pattern and the load of the next share the same shift clocks. Every stage uses the same clock, the same test-mode line and the same synchronous active-high reset.

Top module: `scan_register_bank`

## Requirements
- R1: A clock edge with `rst` high clears all `CHAIN_LEN` stages to zero, whatever the value of `test_mode`.
- R2: With `test_mode` low (functional mode), every clock edge loads `present_state` with the value `next_state` had at that edge.
- R3: With `test_mode` high (shift mode), every clock edge loads stage 0 from `scan_in` and loads stage i from stage i-1, for i from 1 to `CHAIN_LEN`-1. Stage i is bit i of `present_state`, and bit 0 is the stage nearest `scan_in`.
- R4: `scan_out` equals the last stage, bit `CHAIN_LEN`-1 of `present_state`, in every cycle and in both modes.
- R5: After `CHAIN_LEN` shift clocks, the bit applied at `scan_in` on shift clock k (k = 0 first) sits in stage `CHAIN_LEN`-1-k.
- R6: During an unload of `CHAIN_LEN` shift clocks, `scan_out` presents the held state from the top stage down: stage `CHAIN_LEN`-1 before the first shift clock, and stage `CHAIN_LEN`-1-j before shift clock j.
- R7: In shift mode `next_state` has no effect on any stage.
- R8: A load of `CHAIN_LEN` shift clocks, then one functional clock, then an unload of `CHAIN_LEN` shift clocks returns at `scan_out` the `next_state` value applied at the capture clock. Meanwhile `scan_in` loads the next pattern over the same clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages |
| rst | input | 1 | Synchronous active-high reset; clears every stage |
| test_mode | input | 1 | 1 selects serial shift, 0 selects functional capture |
| scan_in | input | 1 | Serial input feeding stage 0 in shift mode |
| scan_out | output | 1 | Serial output; the value of the last stage |
| next_state | input | CHAIN_LEN | Next-state bus from the combinational logic |
| present_state | output | CHAIN_LEN | Present-state bus to the combinational logic; bit i is stage i |

## Verification
The bench first shifts a directed asymmetric pattern through the chain. A reversed chain or a missing stage would put the bits in the wrong places and would fail the per-stage placement check. A full load, capture and unload cycle follows, with a new pattern shifted in as the old one comes out. This separates a correct one-clock capture from a chain that never leaves shift mode or that loses its first or last bit. The bench then applies resets in shift mode and random streams that mix modes, random next-state values and random serial bits. These streams tell apart wrong selector polarity, a leak of `next_state` into shift mode, and a reset that works in only one mode.

// File: rtl/scan_reg_pkg.sv
package scan_reg_pkg;

    // Operating mode of every stage in the bank.
    typedef enum logic {
        MODE_FUNCTIONAL = 1'b0,
        MODE_SHIFT      = 1'b1
    } scan_mode_e;

    // The two candidate data values a stage can load.
    typedef struct packed {
        logic func_d;
        logic shift_d;
    } stage_src_t;

    function automatic scan_mode_e decode_mode(input logic tm);
        return tm ? MODE_SHIFT : MODE_FUNCTIONAL;
    endfunction

    function automatic logic pick_source(input scan_mode_e mode, input stage_src_t src);
        return (mode == MODE_SHIFT) ? src.shift_d : src.func_d;
    endfunction

endpackage

// File: rtl/scan_stage.sv
module scan_stage
    import scan_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  scan_mode_e mode,
    input  stage_src_t src,
    output logic       q
);

    logic d_sel;
    logic past_valid;

    always_comb begin
        d_sel = pick_source(mode, src);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= d_sel;
        end
    end

    always_ff @(posedge clk) begin
        past_valid <= 1'b1;
    end

    AST_STAGE_RESET: assert property (@(posedge clk)
        past_valid && $past(rst) |-> q == 1'b0); // R1

    AST_STAGE_FUNC: assert property (@(posedge clk) disable iff (rst)
        past_valid && !$past(rst) && $past(mode) == MODE_FUNCTIONAL |-> q == $past(src.func_d)); // R2

    AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        past_valid && !$past(rst) && $past(mode) == MODE_SHIFT |-> q == $past(src.shift_d)); // R3

endmodule

// File: rtl/scan_chain_core.sv
module scan_chain_core
    import scan_reg_pkg::*;
#(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  scan_mode_e           mode,
    input  logic                 serial_in,
    input  logic [CHAIN_LEN-1:0] func_bus,
    output logic [CHAIN_LEN-1:0] state_bus,
    output logic                 serial_tail
);

    localparam int LAST = CHAIN_LEN - 1;

    logic past_valid;

    for (genvar g = 0; g < CHAIN_LEN; g++) begin : g_stage
        stage_src_t src;
        always_comb begin
            src.func_d = func_bus[g];
            if (g == 0) begin
                src.shift_d = serial_in;
            end else begin
                src.shift_d = state_bus[(g == 0) ? 0 : g - 1];
            end
        end

        scan_stage u_stage (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .src  (src),
            .q    (state_bus[g])
        );
    end

    assign serial_tail = state_bus[LAST];

    always_ff @(posedge clk) begin
        past_valid <= 1'b1;
    end

    AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (rst)
        past_valid && !$past(rst) && $past(mode) == MODE_SHIFT |-> state_bus[0] == $past(serial_in)); // R3

    AST_SHIFT_TAIL_MOVES: assert property (@(posedge clk) disable iff (rst)
        past_valid && !$past(rst) && $past(mode) == MODE_SHIFT |-> serial_tail == $past(state_bus[LAST-1])); // R6

    AST_SHIFT_IGNORES_FUNC: assert property (@(posedge clk) disable iff (rst)
        past_valid && !$past(rst) && $past(mode) == MODE_SHIFT && $stable(func_bus)
        |-> state_bus[LAST:1] == $past(state_bus[LAST-1:0])); // R7

endmodule

// File: rtl/scan_register_bank.sv
module scan_register_bank
    import scan_reg_pkg::*;
#(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 test_mode,
    input  logic                 scan_in,
    output logic                 scan_out,
    input  logic [CHAIN_LEN-1:0] next_state,
    output logic [CHAIN_LEN-1:0] present_state
);

    scan_mode_e mode;
    logic       past_valid;

    always_comb begin
        mode = decode_mode(test_mode);
    end

    scan_chain_core #(
        .CHAIN_LEN (CHAIN_LEN)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .serial_in   (scan_in),
        .func_bus    (next_state),
        .state_bus   (present_state),
        .serial_tail (scan_out)
    );

    always_ff @(posedge clk) begin
        past_valid <= 1'b1;
    end

    AST_BANK_RESET: assert property (@(posedge clk)
        past_valid && $past(rst) |-> present_state == '0 && scan_out == 1'b0); // R1

    AST_BANK_FUNCTIONAL: assert property (@(posedge clk) disable iff (rst)
        past_valid && !$past(rst) && !$past(test_mode) |-> present_state == $past(next_state)); // R2

    AST_BANK_SHIFT_OUT: assert property (@(posedge clk) disable iff (rst)
        past_valid && !$past(rst) && $past(test_mode) |-> scan_out == $past(present_state[CHAIN_LEN-2])); // R4

endmodule

// File: tb/test_scan_register_bank.sv
module test_scan_register_bank;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         test_mode = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] next_state = '0;
    logic         scan_out;
    logic [N-1:0] present_state;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] model = '0;

    always #4 clk = ~clk;

    scan_register_bank #(.CHAIN_LEN(N)) i_scan_register_bank (
        .clk           (clk),
        .rst           (rst),
        .test_mode     (test_mode),
        .scan_in       (scan_in),
        .scan_out      (scan_out),
        .next_state    (next_state),
        .present_state (present_state)
    );

    // Expected next state, written from R1, R2 and R3.
    function automatic logic [N-1:0] expect_next(input logic r, input logic tm, input logic si,
                                                 input logic [N-1:0] ns, input logic [N-1:0] cur);
        if (r) return '0;
        if (tm) return {cur[N-2:0], si};
        return ns;
    endfunction

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One clock: drive away from the edge, update the model, sample after the edge.
    task automatic cyc(input logic r, input logic tm, input logic si, input logic [N-1:0] ns);
        rst = r; test_mode = tm; scan_in = si; next_state = ns;
        @(posedge clk);
        model = expect_next(r, tm, si, ns, model);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] pat;
        logic [N-1:0] cap;
        logic [N-1:0] nxt;
        logic [N-1:0] got;
        void'($urandom(32'd1234));

        // R1: reset state in functional mode
        cyc(1'b1, 1'b0, 1'b1, '1);
        cyc(1'b1, 1'b0, 1'b1, '1);
        chk("R1 reset functional", present_state, '0);
        chk("R4 scan_out after reset", {{(N-1){1'b0}}, scan_out}, '0);

        // R5: directed asymmetric load
        pat = 8'b1011_0010;
        for (int k = 0; k < N; k++) cyc(1'b0, 1'b1, pat[k], 8'hA5);
        got = '0;
        for (int k = 0; k < N; k++) got[N-1-k] = pat[k];
        chk("R5 loaded placement", present_state, got);
        chk("R7 shift ignores next_state", present_state, model);

        // R8: one capture clock
        cap = 8'b0110_1101;
        cyc(1'b0, 1'b0, 1'b0, cap);
        chk("R2 capture", present_state, cap);

        // R6/R8: unload while loading a new pattern
        nxt = 8'b1100_0101;
        got = '0;
        for (int j = 0; j < N; j++) begin
            got[N-1-j] = scan_out;
            cyc(1'b0, 1'b1, nxt[j], ~cap);
        end
        chk("R6 unload order", got, cap);
        for (int k = 0; k < N; k++) pat[N-1-k] = nxt[k];
        chk("R8 overlapped load", present_state, pat);

        // R1: reset while in shift mode
        cyc(1'b1, 1'b1, 1'b1, '1);
        chk("R1 reset shift mode", present_state, '0);

        // R7: shift zeros under changing next_state keeps the chain at zero
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 1'b1, 1'b0, N'($urandom));
            chk("R7 next_state ignored", present_state, '0);
        end

        // Random mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic r, tm, si;
            logic [N-1:0] ns;
            r  = ($urandom_range(0, 29) == 0);
            tm = $urandom_range(0, 1);
            si = $urandom_range(0, 1);
            ns = N'($urandom);
            cyc(r, tm, si, ns);
            if (r) chk("R1 random reset", present_state, model);
            else if (tm) chk("R3 random shift", present_state, model);
            else chk("R2 random functional", present_state, model);
            chk("R4 scan_out tail", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, model[N-1]});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule